// File: doc/BRIEF.md
# Floating-Point Control and Status Register Unit

This block keeps the control and status word of a scalar floating-point unit and applies the rules that govern how that word changes. Software uses an indexed control-register port to read and write the word. The arithmetic pipeline reports the outcome of each completed operation as a valid pulse, five exception bits and a flag that says whether it wants to write back a result. The compare unit sets and clears the eight condition codes by index.

The unit drives the current rounding mode, the flush control and the condition codes straight to the datapath. One cycle after each event it gives a decision. An event is an operation report, or a control write to the status word. The decision is held in a small event state machine with four named states:

- `EV_QUIET`: no decision is pending.
- `EV_OP_WB`: the last operation may write its result back.
- `EV_OP_TRAP`: the last operation raised an enabled exception. Its result is suppressed and a trap is requested.
- `EV_CTL_TRAP`: a control write left an enabled cause bit set.

The transitions are evaluated every cycle, whatever the current state is:

- An operation report goes to `EV_OP_TRAP` if an enabled cause bit is set after the update.
- Otherwise, an operation report goes to `EV_OP_WB` if writeback was requested, and to `EV_QUIET` if it was not.
- With no operation report, a trapping control write goes to `EV_CTL_TRAP`.
- Anything else goes to `EV_QUIET`.

Top module: `fcsr_unit`

## Requirements
- R1: After reset:
  - the rounding mode, flush, enable, flag and cause fields are 0, as are all condition codes;
  - `trap_req` and `wb_permit` are 0;
  - reading index 31 returns 0.
- R2: The read port is combinational. Index 31 returns the status word, laid out as follows. Every other index, including 0 (the revision identifier), reads as 0.

  | Bits | Field |
  |------|-------|
  | 1:0 | rounding mode |
  | 6:2 | flags |
  | 11:7 | enables |
  | 16:12 | cause |
  | 17 | unimplemented cause, always 0 |
  | 22:18 | zero |
  | 23 | condition code 0 |
  | 24 | flush |
  | 31:25 | condition codes 7..1 |

  Within the flag, enable and cause fields, the lowest bit is inexact, followed by underflow, overflow, divide-by-zero and invalid.
- R3: A control write to index 31 changes only the rounding mode, flags, enables and flush fields. Cause bits and condition codes are kept. A write to any other index changes nothing.
- R4: `rnd_mode` shows field bits 1:0, where 0 = nearest, 1 = toward zero, 2 = toward +infinity and 3 = toward -infinity. `flush_en` shows bit 24.
- R5: On an operation report (`op_valid`), the cause field is replaced by `op_exc`. The bits of `op_exc` run from inexact in bit 0 to invalid in bit 4. Each set bit of `op_exc` is also ORed into its sticky flag. Flags are never cleared except by a control write.
- R6: In the cycle after an operation report, `trap_req` is 1 exactly when the new cause AND the enables is nonzero.
- R7: In the cycle after an operation report, `wb_permit` is 1 exactly when writeback was requested and no trap was raised. A trapping operation still updates its cause and flags.
- R8: A control write to index 31 that leaves an enabled cause bit set raises `trap_req` in the next cycle, with `wb_permit` low.
- R9: When `cc_wr_en` is set, condition code `cc_idx` takes the value `cc_val` and the other codes are kept. `cond_codes` shows all eight codes, bit i being code i.
- R10: When a control write to index 31 and an operation report arrive in the same cycle:
  - the rounding mode, flush and enables come from the written data;
  - the flags become the written flags ORed with `op_exc`;
  - the cause becomes `op_exc`;
  - the trap is judged against the new enables.
- R11: `trap_req` and `wb_permit` are never both high. Both are low in the cycle after a cycle that has no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cr_rd_idx | input | 5 | Control register read index |
| cr_rd_data | output | 32 | Control register read data |
| cr_wr_en | input | 1 | Control register write strobe |
| cr_wr_idx | input | 5 | Control register write index |
| cr_wr_data | input | 32 | Control register write data |
| op_valid | input | 1 | Operation completion report |
| op_exc | input | 5 | Exception bits of the operation (inexact..invalid) |
| op_wb_req | input | 1 | Operation wants to write back its result |
| cc_wr_en | input | 1 | Condition-code update strobe from compare |
| cc_idx | input | 3 | Condition-code index |
| cc_val | input | 1 | Condition-code value |
| rnd_mode | output | 2 | Current rounding mode |
| flush_en | output | 1 | Flush control bit |
| cond_codes | output | 8 | Condition codes 7..0 |
| trap_req | output | 1 | Trap request, one cycle after the event |
| wb_permit | output | 1 | Writeback permission, one cycle after the operation |

## Verification
The assertions watch a set of rules on every cycle:
- the cause field reloads from each report;
- flags are sticky between control writes;
- a plain control write leaves the cause field stable;
- the rounding mode follows a write;
- condition codes hold when no compare update arrives;
- no decision appears after an idle cycle, and the trap and permit outputs are never both set.

Some behaviour only the bench scenarios can show. These are the exact status word seen at the read port, the zero returned by every other index, and trap raising under each combination of cause and enable. They also include a control write that turns on an enable while a cause bit is still set, and the merging of a write and a report that arrive in the same cycle.

// File: rtl/fcsr_pkg.sv
package fcsr_pkg;
    localparam int EXC_N      = 5;
    localparam int WORD_W     = 32;
    localparam int RM_LO      = 0;
    localparam int FLAG_LO    = 2;
    localparam int EN_LO      = 7;
    localparam int CAUSE_LO   = 12;
    localparam int CAUSE_UNIM = 17;
    localparam int CC0_POS    = 23;
    localparam int FLUSH_POS  = 24;
    localparam int CCHI_LO    = 25;

    typedef enum logic [1:0] {
        EV_QUIET    = 2'd0,
        EV_OP_WB    = 2'd1,
        EV_OP_TRAP  = 2'd2,
        EV_CTL_TRAP = 2'd3
    } ev_state_t;

    typedef struct packed {
        logic [1:0]       rm;
        logic             flush;
        logic [EXC_N-1:0] en;
        logic [EXC_N-1:0] flag;
        logic [EXC_N-1:0] cause;
    } csr_fields_t;
endpackage

// File: rtl/fcsr_word.sv
module fcsr_word
    import fcsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_hit,
    input  logic [WORD_W-1:0] wdata,
    input  logic              op_valid,
    input  logic [EXC_N-1:0]  op_exc,
    output csr_fields_t       fld_q,
    output logic              trap_next
);
    csr_fields_t fld_n;

    // Control write is applied first; an operation report in the same
    // cycle then owns the cause field and ORs onto the flag field.
    always_comb begin
        fld_n = fld_q;
        if (ctl_hit) begin
            fld_n.rm    = wdata[RM_LO +: 2];
            fld_n.flush = wdata[FLUSH_POS];
            fld_n.en    = wdata[EN_LO +: EXC_N];
            fld_n.flag  = wdata[FLAG_LO +: EXC_N];
        end
        if (op_valid) begin
            fld_n.cause = op_exc;
            fld_n.flag  = fld_n.flag | op_exc;
        end
    end

    assign trap_next = (op_valid || ctl_hit) && ((fld_n.cause & fld_n.en) != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fld_q <= '0;
        end else begin
            fld_q <= fld_n;
        end
    end

    p_cause_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> fld_q.cause == $past(op_exc));

    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_hit |=> (fld_q.flag & $past(fld_q.flag)) == $past(fld_q.flag));

    p_cause_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_hit && !op_valid) |=> $stable(fld_q.cause));

    p_rm_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_hit |=> fld_q.rm == $past(wdata[1:0]));
endmodule

// File: rtl/fcsr_cc_bank.sv
module fcsr_cc_bank #(
    parameter int NUM_CC = 8,
    localparam int CC_IDX_W = (NUM_CC > 1) ? $clog2(NUM_CC) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [CC_IDX_W-1:0] wr_idx,
    input  logic                wr_val,
    output logic [NUM_CC-1:0]   cc_q
);
    for (genvar g = 0; g < NUM_CC; g++) begin : g_cc
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cc_q[g] <= 1'b0;
            end else if (wr_en && (wr_idx == CC_IDX_W'(g))) begin
                cc_q[g] <= wr_val;
            end
        end
    end

    p_cc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cc_q));

    p_cc_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> $countones(cc_q ^ $past(cc_q)) <= 1);
endmodule

// File: rtl/fcsr_event_fsm.sv
module fcsr_event_fsm
    import fcsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic op_valid,
    input  logic op_wb_req,
    input  logic ctl_hit,
    input  logic trap_next,
    output logic trap_req,
    output logic wb_permit
);
    ev_state_t state_q, state_n;

    always_comb begin
        if (op_valid) begin
            if (trap_next)      state_n = EV_OP_TRAP;
            else if (op_wb_req) state_n = EV_OP_WB;
            else                state_n = EV_QUIET;
        end else if (ctl_hit && trap_next) begin
            state_n = EV_CTL_TRAP;
        end else begin
            state_n = EV_QUIET;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EV_QUIET;
        else        state_q <= state_n;
    end

    always_comb begin
        trap_req  = 1'b0;
        wb_permit = 1'b0;
        unique case (state_q)
            EV_QUIET:    ;
            EV_OP_WB:    wb_permit = 1'b1;
            EV_OP_TRAP:  trap_req  = 1'b1;
            EV_CTL_TRAP: trap_req  = 1'b1;
            default:     ;
        endcase
    end

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !ctl_hit) |=> (!trap_req && !wb_permit));

    p_no_wb_unasked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_wb_req) |=> !wb_permit);

    p_wb_granted_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_wb_req && !trap_next) |=> wb_permit);

    p_ctl_trap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_hit && trap_next) |=> (trap_req && !wb_permit));
endmodule

// File: rtl/fcsr_unit.sv
module fcsr_unit
    import fcsr_pkg::*;
#(
    parameter int IDX_W   = 5,
    parameter int CSR_IDX = 31,
    parameter int NUM_CC  = 8,
    localparam int CC_IDX_W = (NUM_CC > 1) ? $clog2(NUM_CC) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_W-1:0]    cr_rd_idx,
    output logic [WORD_W-1:0]   cr_rd_data,
    input  logic                cr_wr_en,
    input  logic [IDX_W-1:0]    cr_wr_idx,
    input  logic [WORD_W-1:0]   cr_wr_data,
    input  logic                op_valid,
    input  logic [EXC_N-1:0]    op_exc,
    input  logic                op_wb_req,
    input  logic                cc_wr_en,
    input  logic [CC_IDX_W-1:0] cc_idx,
    input  logic                cc_val,
    output logic [1:0]          rnd_mode,
    output logic                flush_en,
    output logic [NUM_CC-1:0]   cond_codes,
    output logic                trap_req,
    output logic                wb_permit
);
    csr_fields_t fld_q;
    logic        trap_next;
    logic        ctl_hit;
    logic [WORD_W-1:0] word;

    assign ctl_hit = cr_wr_en && (cr_wr_idx == IDX_W'(CSR_IDX));

    fcsr_word u_word (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_hit   (ctl_hit),
        .wdata     (cr_wr_data),
        .op_valid  (op_valid),
        .op_exc    (op_exc),
        .fld_q     (fld_q),
        .trap_next (trap_next)
    );

    fcsr_cc_bank #(.NUM_CC(NUM_CC)) u_cc (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cc_wr_en),
        .wr_idx (cc_idx),
        .wr_val (cc_val),
        .cc_q   (cond_codes)
    );

    fcsr_event_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_wb_req (op_wb_req),
        .ctl_hit   (ctl_hit),
        .trap_next (trap_next),
        .trap_req  (trap_req),
        .wb_permit (wb_permit)
    );

    // Status word assembly; code 0 sits apart from the upper codes.
    always_comb begin
        word = '0;
        word[RM_LO +: 2]        = fld_q.rm;
        word[FLAG_LO +: EXC_N]  = fld_q.flag;
        word[EN_LO +: EXC_N]    = fld_q.en;
        word[CAUSE_LO +: EXC_N] = fld_q.cause;
        word[CAUSE_UNIM]        = 1'b0;
        word[FLUSH_POS]         = fld_q.flush;
        for (int i = 0; i < NUM_CC; i++) begin
            if (i == 0) word[CC0_POS] = cond_codes[i];
            else if (CCHI_LO + i - 1 < WORD_W) word[CCHI_LO + i - 1] = cond_codes[i];
        end
    end

    assign cr_rd_data = (cr_rd_idx == IDX_W'(CSR_IDX)) ? word : '0;
    assign rnd_mode   = fld_q.rm;
    assign flush_en   = fld_q.flush;

    p_excl_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap_req && wb_permit));

    p_op_trap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (trap_req == ((fld_q.cause & fld_q.en) != '0)));
endmodule

// File: tb/fcsr_unit_tb.sv
module fcsr_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  cr_rd_idx = 5'd31;
    logic [31:0] cr_rd_data;
    logic        cr_wr_en = 1'b0;
    logic [4:0]  cr_wr_idx = '0;
    logic [31:0] cr_wr_data = '0;
    logic        op_valid = 1'b0;
    logic [4:0]  op_exc = '0;
    logic        op_wb_req = 1'b0;
    logic        cc_wr_en = 1'b0;
    logic [2:0]  cc_idx = '0;
    logic        cc_val = 1'b0;
    logic [1:0]  rnd_mode;
    logic        flush_en;
    logic [7:0]  cond_codes;
    logic        trap_req;
    logic        wb_permit;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [1:0] m_rm;
    logic       m_fl;
    logic [4:0] m_en, m_flag, m_cause;
    logic [7:0] m_cc;
    logic       e_trap, e_wb;

    always #10 clk = ~clk;

    fcsr_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .cr_rd_idx(cr_rd_idx), .cr_rd_data(cr_rd_data),
        .cr_wr_en(cr_wr_en), .cr_wr_idx(cr_wr_idx), .cr_wr_data(cr_wr_data),
        .op_valid(op_valid), .op_exc(op_exc), .op_wb_req(op_wb_req),
        .cc_wr_en(cc_wr_en), .cc_idx(cc_idx), .cc_val(cc_val),
        .rnd_mode(rnd_mode), .flush_en(flush_en), .cond_codes(cond_codes),
        .trap_req(trap_req), .wb_permit(wb_permit)
    );

    function automatic logic [31:0] exp_word();
        logic [31:0] w = '0;
        w[1:0]   = m_rm;
        w[6:2]   = m_flag;
        w[11:7]  = m_en;
        w[16:12] = m_cause;
        w[23]    = m_cc[0];
        w[24]    = m_fl;
        w[31:25] = m_cc[7:1];
        return w;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cycle(input logic we, input logic [4:0] widx, input logic [31:0] wd,
                         input logic ov, input logic [4:0] ex, input logic wbr,
                         input logic ccw, input logic [2:0] cci, input logic ccv);
        logic ctl;
        logic [4:0] cn, en_n;
        cr_wr_en = we; cr_wr_idx = widx; cr_wr_data = wd;
        op_valid = ov; op_exc = ex; op_wb_req = wbr;
        cc_wr_en = ccw; cc_idx = cci; cc_val = ccv;
        ctl = we && (widx == 5'd31);
        if (ctl) begin
            m_rm = wd[1:0]; m_fl = wd[24]; m_en = wd[11:7]; m_flag = wd[6:2];
        end
        if (ov) begin
            m_cause = ex; m_flag = m_flag | ex;
        end
        if (ccw) m_cc[cci] = ccv;
        cn = m_cause; en_n = m_en;
        e_trap = (ov || ctl) && ((cn & en_n) != 0);
        e_wb   = ov && wbr && !e_trap;
        @(posedge clk); #2;
        cr_wr_en = 0; op_valid = 0; cc_wr_en = 0;
        cr_rd_idx = 5'd31; #1;
        check("R2/R3/R5/R10 status word", cr_rd_data, exp_word());
        check("R6/R8 trap_req", {31'd0, trap_req}, {31'd0, e_trap});
        check("R7 wb_permit", {31'd0, wb_permit}, {31'd0, e_wb});
        check("R9 cond_codes", {24'd0, cond_codes}, {24'd0, m_cc});
        check("R4 rnd_mode/flush", {29'd0, flush_en, rnd_mode}, {29'd0, m_fl, m_rm});
        check("R11 exclusive", {31'd0, trap_req & wb_permit}, 32'd0);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] wd;
        m_rm = 0; m_fl = 0; m_en = 0; m_flag = 0; m_cause = 0; m_cc = 0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1; #1;
        // R1 reset state
        check("R1 status word", cr_rd_data, 32'd0);
        check("R1 trap/wb", {30'd0, trap_req, wb_permit}, 32'd0);
        check("R1 cc/rm/flush", {21'd0, cond_codes, flush_en, rnd_mode}, 32'd0);

        // R4 each rounding mode
        for (int k = 0; k < 4; k++) cycle(1, 5'd31, 32'(k), 0, 0, 0, 0, 0, 0);
        // R3 write with every bit set: cause and reserved stay 0
        cycle(1, 5'd31, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0);
        // R3 write to other index has no effect
        cycle(1, 5'd5, 32'h0000_0000, 0, 0, 0, 0, 0, 0);
        // R2 index 0 and 7 read zero
        cr_rd_idx = 5'd0; #1;
        check("R2 index0 reads zero", cr_rd_data, 32'd0);
        cr_rd_idx = 5'd7; #1;
        check("R2 index7 reads zero", cr_rd_data, 32'd0);
        // clear enables/flags
        cycle(1, 5'd31, 32'd0, 0, 0, 0, 0, 0, 0);
        // R5/R7 operation without enables: writeback permitted
        cycle(0, 0, 0, 1, 5'b00101, 1, 0, 0, 0);
        // R5 second op replaces cause, flags accumulate
        cycle(0, 0, 0, 1, 5'b10000, 1, 0, 0, 0);
        // R8 enable invalid while cause invalid set -> trap from control write
        cycle(1, 5'd31, 32'h0000_0800, 0, 0, 0, 0, 0, 0);
        // R6 op with enabled exception traps and blocks writeback
        cycle(0, 0, 0, 1, 5'b10000, 1, 0, 0, 0);
        // R6 op with disabled exception only: no trap
        cycle(0, 0, 0, 1, 5'b00001, 1, 0, 0, 0);
        // R10 simultaneous write and op
        cycle(1, 5'd31, 32'h0000_0084, 1, 5'b00001, 1, 0, 0, 0);
        // R11 idle cycle
        cycle(0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R9 condition codes
        cycle(0, 0, 0, 0, 0, 0, 1, 3'd0, 1);
        cycle(0, 0, 0, 0, 0, 0, 1, 3'd7, 1);
        cycle(0, 0, 0, 0, 0, 0, 1, 3'd0, 0);

        void'($urandom(32'd20240611));
        for (int i = 0; i < 400; i++) begin
            wd = $urandom;
            if (($urandom % 4) != 0) wd[11:7] = wd[11:7] & 5'($urandom);
            cycle(($urandom % 3) == 0, (($urandom % 2) == 0) ? 5'd31 : 5'($urandom),
                  wd, ($urandom % 2) == 0, 5'($urandom) & 5'($urandom), ($urandom % 4) != 0,
                  ($urandom % 2) == 0, 3'($urandom), 1'($urandom));
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule